// File: doc/BRIEF.md
# Up-Counting Timer with Capture

A memory-mapped 32-bit timer for a simple register bus: an address, a write enable, write data and a combinational read-data return. The core is an up-counter that advances while its start bit is set, either every clock or, with the prescaler on, once per 2^(p+1) clocks. When the counter passes the all-ones value it flags an overflow. It then continues from the load register if auto-reload is on, or wraps to zero and stops if auto-reload is off. A comparator flags a match when the count reaches a programmed value. A capture unit samples an external pin through a two-stage synchroniser and latches the count on a chosen edge. In second-event mode it latches only on every other selected edge.

The three events (match, overflow, capture) set bits in a raw status register. Software can always read that register, whether or not the bits are enabled. It clears bits only by writing ones to the masked status register. The enable mask has one write-one-to-set alias and one write-one-to-clear alias, and both read back the mask. The interrupt output is high while any enabled status bit is set. A soft reset is run by a two-state machine. In ST_RUN the block works normally, and a write with bit 1 set to the interface control register moves it to ST_SRST. In ST_SRST every register is held at its reset value and the busy flag reads 1. After SRST_CYCLES cycles the machine returns to ST_RUN.

Top module: `ucnt_timer`

## Requirements
- R1: After reset the counter, control, load, match, capture, status and enable registers read 0, irq is 0, offset 0x00 reads the ID_VALUE parameter and offset 0x10 reads 0.
- R2: With start (control bit 0) set and the prescaler off, the counter at 0x3C rises by one per clock. With start clear it holds its value.
- R3: With the prescaler enabled (control bit 5) and value p (control bits 4:2), the counter advances once every 2^(p+1) clocks.
- R4: A write to 0x3C sets the count. Starting from 0xFFFFFFFF minus N, overflow status (bit 1) is set on tick N+1 and not before.
- R5: On overflow with auto-reload (control bit 1) set, the counter continues from the load register at 0x40.
- R6: On overflow with auto-reload clear, the counter becomes 0 and the start bit clears, so the counter stays at 0.
- R7: Any write to 0x44 copies the load register into the counter.
- R8: With compare enable (control bit 6) set, match status (bit 0) is set once when the counter becomes equal to 0x4C. It does not set again while the equality persists.
- R9: Capture edge select (control bits 9:8) means 0 none, 1 rising, 2 falling, 3 both. On a selected edge the count is latched into 0x50 and capture status (bit 2) is set. Unselected edges change neither.
- R10: With second-event mode (control bit 13) set, only every second selected edge captures.
- R11: 0x24 shows raw status regardless of enables and ignores writes. 0x28 reads raw AND enable. Writing 1 to a bit of 0x28 clears that raw bit, and writing 0 leaves it unchanged.
- R12: Writes to 0x2C set and writes to 0x30 clear only the enable bits written as 1. Both offsets read the mask. irq is high exactly while some enabled status bit is set.
- R13: Writing bit 1 of 0x54 starts a soft reset. Bit 0 of 0x10 reads 1 for SRST_CYCLES cycles and then 0, and all registers return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| cap_in | input | 1 | External capture pin, asynchronous |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench targets the boundary of the overflow: a count of all-ones minus two must not flag overflow after two ticks but must flag it on the third. An off-by-one comparator would flag too early or reload the wrong value. Prescaler runs are measured over a fixed window, so a divider that counts 2^p instead of 2^(p+1) leaves a different count. Match is checked while the equality is held with the counter frozen, which exposes a level-sensitive comparator that re-raises status after it is cleared. Capture uses a frozen counter so the latched value is exact. It covers an unselected edge, which a design ignoring the edge-select field would capture, and the skipped first edge of second-event mode. The soft reset busy flag is read mid-sequence and after completion.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int PS_W = 3;
    localparam int NEV  = 3;

    localparam int EV_MATCH = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_CAP   = 2;

    localparam logic [AW-1:0] A_ID    = 8'h00;
    localparam logic [AW-1:0] A_CFG   = 8'h10;
    localparam logic [AW-1:0] A_RAW   = 8'h24;
    localparam logic [AW-1:0] A_STAT  = 8'h28;
    localparam logic [AW-1:0] A_ENSET = 8'h2C;
    localparam logic [AW-1:0] A_ENCLR = 8'h30;
    localparam logic [AW-1:0] A_CTL   = 8'h38;
    localparam logic [AW-1:0] A_CNT   = 8'h3C;
    localparam logic [AW-1:0] A_LOAD  = 8'h40;
    localparam logic [AW-1:0] A_TRIG  = 8'h44;
    localparam logic [AW-1:0] A_MATCH = 8'h4C;
    localparam logic [AW-1:0] A_CAP   = 8'h50;
    localparam logic [AW-1:0] A_ICTRL = 8'h54;

    typedef enum logic {ST_RUN, ST_SRST} srst_state_t;
endpackage

// File: rtl/ucnt_prescale.sv
module ucnt_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic            en,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = 1 << PS_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   lim_w;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim_w = ((DIV_W+1)'(1) << (32'(sel) + 1)) - (DIV_W+1)'(1);
        lim   = lim_w[DIV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    div_q <= '0;
        else if (clr || !run || !en)   div_q <= '0;
        else if (div_q == lim)         div_q <= '0;
        else                           div_q <= div_q + 1'b1;
    end

    assign tick = run && (!en || (div_q == lim));
endmodule

// File: rtl/ucnt_capture.sv
module ucnt_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         pin,
    input  logic [1:0]   edge_sel,
    input  logic         second,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         cap_evt
);
    logic [2:0] sync_q;
    logic       pend_q;
    logic       rise, fall, hit;

    assign rise    = sync_q[1] && !sync_q[2];
    assign fall    = !sync_q[1] && sync_q[2];
    assign hit     = (edge_sel[0] && rise) || (edge_sel[1] && fall);
    assign cap_evt = hit && (!second || pend_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val <= '0;
            pend_q  <= 1'b0;
        end else if (clr) begin
            cap_val <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (cap_evt)      cap_val <= cnt;
            if (!second)      pend_q  <= 1'b0;
            else if (hit)     pend_q  <= !pend_q;
        end
    end
endmodule

// File: rtl/ucnt_irq.sv
module ucnt_irq #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [NEV-1:0] evt,
    input  logic [NEV-1:0] ack,
    input  logic [NEV-1:0] en_set,
    input  logic [NEV-1:0] en_clr,
    output logic [NEV-1:0] raw,
    output logic [NEV-1:0] en,
    output logic           irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
            en  <= '0;
        end else if (clr) begin
            raw <= '0;
            en  <= '0;
        end else begin
            raw <= (raw & ~ack) | evt;
            en  <= (en | en_set) & ~en_clr;
        end
    end

    assign irq = |(raw & en);
endmodule

// File: rtl/ucnt_timer.sv
module ucnt_timer
    import ucnt_pkg::*;
#(
    parameter int          SRST_CYCLES = 4,
    parameter logic [31:0] ID_VALUE    = 32'h0A11_0201
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cap_in,
    output logic          irq
);
    localparam int          SRST_W = $clog2(SRST_CYCLES + 1);
    localparam logic [DW-1:0] MAXV = '1;

    srst_state_t       state_q;
    logic [SRST_W-1:0] left_q;
    logic              busy, soft_go, clr_all, wr_ok;

    logic              start_q, reload_q, ps_en_q, cmp_en_q, cap2_q;
    logic [PS_W-1:0]   ps_q;
    logic [1:0]        cap_sel_q;
    logic [DW-1:0]     cnt_q, load_q, match_q, cap_val;
    logic              eq_q, eq, tick, cap_evt, cnt_wr, trig_wr, at_max;
    logic [NEV-1:0]    evt, raw, en, ack, en_set, en_clr;
    logic [DW-1:0]     ctl_rd;

    assign wr_ok   = wr_en && (state_q == ST_RUN);
    assign soft_go = wr_ok && (addr == A_ICTRL) && wdata[1];
    assign clr_all = soft_go || busy;
    assign cnt_wr  = wr_ok && (addr == A_CNT);
    assign trig_wr = wr_ok && (addr == A_TRIG);
    assign at_max  = (cnt_q == MAXV);

    // soft reset state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: if (soft_go) begin
                    state_q <= ST_SRST;
                    left_q  <= SRST_W'(SRST_CYCLES - 1);
                end
                ST_SRST: if (left_q == '0) state_q <= ST_RUN;
                         else              left_q  <= left_q - 1'b1;
            endcase
        end
    end

    // soft reset outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  busy = 1'b0;
            ST_SRST: busy = 1'b1;
        endcase
    end

    ucnt_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .run(start_q && !busy),
        .en(ps_en_q), .sel(ps_q), .tick(tick)
    );

    ucnt_capture #(.W(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .pin(cap_in),
        .edge_sel(cap_sel_q), .second(cap2_q), .cnt(cnt_q),
        .cap_val(cap_val), .cap_evt(cap_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0; reload_q <= 1'b0; ps_q <= '0; ps_en_q <= 1'b0;
            cmp_en_q <= 1'b0; cap_sel_q <= '0; cap2_q <= 1'b0;
            cnt_q <= '0; load_q <= '0; match_q <= '0; eq_q <= 1'b0;
        end else if (clr_all) begin
            start_q <= 1'b0; reload_q <= 1'b0; ps_q <= '0; ps_en_q <= 1'b0;
            cmp_en_q <= 1'b0; cap_sel_q <= '0; cap2_q <= 1'b0;
            cnt_q <= '0; load_q <= '0; match_q <= '0; eq_q <= 1'b0;
        end else begin
            eq_q <= eq;
            if (wr_ok && addr == A_CTL) begin
                start_q   <= wdata[0];
                reload_q  <= wdata[1];
                ps_q      <= wdata[2 +: PS_W];
                ps_en_q   <= wdata[5];
                cmp_en_q  <= wdata[6];
                cap_sel_q <= wdata[9:8];
                cap2_q    <= wdata[13];
            end else if (tick && at_max && !reload_q && !cnt_wr && !trig_wr) begin
                start_q <= 1'b0;
            end
            if (wr_ok && addr == A_LOAD)  load_q  <= wdata;
            if (wr_ok && addr == A_MATCH) match_q <= wdata;
            if (cnt_wr)       cnt_q <= wdata;
            else if (trig_wr) cnt_q <= load_q;
            else if (tick)    cnt_q <= at_max ? (reload_q ? load_q : '0) : cnt_q + 1'b1;
        end
    end

    assign eq = cmp_en_q && (cnt_q == match_q);

    always_comb begin
        evt           = '0;
        evt[EV_MATCH] = eq && !eq_q;
        evt[EV_OVF]   = tick && at_max && !cnt_wr && !trig_wr;
        evt[EV_CAP]   = cap_evt;
        ack    = (wr_ok && addr == A_STAT)  ? wdata[NEV-1:0] : '0;
        en_set = (wr_ok && addr == A_ENSET) ? wdata[NEV-1:0] : '0;
        en_clr = (wr_ok && addr == A_ENCLR) ? wdata[NEV-1:0] : '0;
    end

    ucnt_irq #(.NEV(NEV)) u_irq (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .evt(evt), .ack(ack),
        .en_set(en_set), .en_clr(en_clr), .raw(raw), .en(en), .irq(irq)
    );

    always_comb begin
        ctl_rd            = '0;
        ctl_rd[0]         = start_q;
        ctl_rd[1]         = reload_q;
        ctl_rd[2 +: PS_W] = ps_q;
        ctl_rd[5]         = ps_en_q;
        ctl_rd[6]         = cmp_en_q;
        ctl_rd[9:8]       = cap_sel_q;
        ctl_rd[13]        = cap2_q;
    end

    always_comb begin
        case (addr)
            A_ID:            rdata = ID_VALUE;
            A_CFG:           rdata = {{(DW-1){1'b0}}, busy};
            A_RAW:           rdata = {{(DW-NEV){1'b0}}, raw};
            A_STAT:          rdata = {{(DW-NEV){1'b0}}, raw & en};
            A_ENSET, A_ENCLR: rdata = {{(DW-NEV){1'b0}}, en};
            A_CTL:           rdata = ctl_rd;
            A_CNT:           rdata = cnt_q;
            A_LOAD:          rdata = load_q;
            A_MATCH:         rdata = match_q;
            A_CAP:           rdata = cap_val;
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/ucnt_timer_chk.sv
module ucnt_timer_chk
    import ucnt_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wdata,
    input logic [DW-1:0]  cnt_q,
    input logic [DW-1:0]  load_q,
    input logic           start_q,
    input logic           reload_q,
    input logic           tick,
    input logic           busy,
    input logic [NEV-1:0] raw,
    input logic [NEV-1:0] en,
    input logic           irq
);
    localparam logic [DW-1:0] MAXV = '1;

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q && !wr_en && !busy) |=> $stable(cnt_q)); // R2

    AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == MAXV && !wr_en && !busy) |=> raw[EV_OVF]); // R4

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == MAXV && reload_q && !wr_en && !busy) |=> (cnt_q == $past(load_q))); // R5

    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == MAXV && !reload_q && !wr_en && !busy) |=> (cnt_q == '0 && !start_q)); // R6

    AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R12

    AST_EN_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr == A_ENSET && wdata[EV_CAP]) |=> en[EV_CAP]); // R12

    AST_EN_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr == A_ENCLR && wdata[EV_CAP]) |=> !en[EV_CAP]); // R12

    AST_SRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q == '0 && en == '0 && raw == '0 && !irq)); // R13
endmodule

bind ucnt_timer ucnt_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_q(cnt_q), .load_q(load_q), .start_q(start_q), .reload_q(reload_q),
    .tick(tick), .busy(busy), .raw(raw), .en(en), .irq(irq)
);

// File: tb/ucnt_timer_tb.sv
module ucnt_timer_tb;
    localparam logic [31:0] ID = 32'h0A11_0201;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap_in = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = !clk;

    ucnt_timer #(.SRST_CYCLES(4), .ID_VALUE(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .irq(irq)
    );

    // {write, addr, data, expected read}
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0,      ID},           // R1 id
        {1'b0, 8'h3C, 32'h0,      32'h0},        // R1 counter
        {1'b0, 8'h38, 32'h0,      32'h0},        // R1 control
        {1'b0, 8'h28, 32'h0,      32'h0},        // R1 status
        {1'b1, 8'h2C, 32'h5,      32'h0},
        {1'b0, 8'h2C, 32'h0,      32'h5},        // R12 set alias
        {1'b1, 8'h30, 32'h1,      32'h0},
        {1'b0, 8'h30, 32'h0,      32'h4},        // R12 clear alias
        {1'b1, 8'h3C, 32'h1234,   32'h0},
        {1'b0, 8'h3C, 32'h0,      32'h1234},     // R2 write while stopped
        {1'b1, 8'h40, 32'hABCD,   32'h0},
        {1'b1, 8'h44, 32'h0,      32'h0},
        {1'b0, 8'h3C, 32'h0,      32'hABCD},     // R7 trigger
        {1'b1, 8'h24, 32'h7,      32'h0},
        {1'b0, 8'h24, 32'h0,      32'h0},        // R11 raw ignores writes
        {1'b1, 8'h2C, 32'h2,      32'h0},
        {1'b0, 8'h2C, 32'h0,      32'h6}         // R12 set keeps others
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic pin(input logic v);
        @(negedge clk);
        cap_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                chk($sformatf("vector %0d", i), v, VEC[i][31:0]);
            end
        end
        wr(8'h30, 32'h7);

        // R2: ten ticks then frozen
        wr(8'h3C, 32'd100); wr(8'h38, 32'h1); repeat (8) @(negedge clk); wr(8'h38, 32'h0);
        rd(8'h3C, v); chk("R2 count", v, 32'd110);
        repeat (4) @(negedge clk);
        rd(8'h3C, v); chk("R2 frozen", v, 32'd110);

        // R3: prescaler p=0 and p=1 over ten clocks
        wr(8'h3C, 32'h0); wr(8'h38, 32'h21); repeat (8) @(negedge clk); wr(8'h38, 32'h0);
        rd(8'h3C, v); chk("R3 div2", v, 32'd5);
        wr(8'h3C, 32'h0); wr(8'h38, 32'h25); repeat (8) @(negedge clk); wr(8'h38, 32'h0);
        rd(8'h3C, v); chk("R3 div4", v, 32'd2);

        // R4/R5: overflow boundary and reload
        wr(8'h28, 32'h7); wr(8'h40, 32'h10); wr(8'h3C, 32'hFFFF_FFFD);
        wr(8'h38, 32'h3); wr(8'h38, 32'h0);
        rd(8'h3C, v); chk("R4 two ticks", v, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R4 no early ovf", v & 32'h2, 32'h0);
        wr(8'h38, 32'h3); wr(8'h38, 32'h0);
        rd(8'h3C, v); chk("R5 reload", v, 32'h11);
        rd(8'h24, v); chk("R4 ovf set", v & 32'h2, 32'h2);

        // R6: one-shot wrap
        wr(8'h3C, 32'hFFFF_FFFF); wr(8'h38, 32'h1); repeat (4) @(negedge clk);
        rd(8'h3C, v); chk("R6 wrapped", v, 32'h0);
        rd(8'h38, v); chk("R6 start cleared", v, 32'h0);

        // R8: match once per equality
        wr(8'h28, 32'h7); wr(8'h3C, 32'h100); wr(8'h4C, 32'h105);
        wr(8'h38, 32'h41); repeat (8) @(negedge clk); wr(8'h38, 32'h0);
        rd(8'h24, v); chk("R8 match while running", v & 32'h1, 32'h1);
        wr(8'h28, 32'h7); wr(8'h38, 32'h40); wr(8'h3C, 32'h105);
        rd(8'h24, v); chk("R8 match on write", v & 32'h1, 32'h1);
        wr(8'h28, 32'h1); repeat (4) @(negedge clk);
        rd(8'h24, v); chk("R8 no refire", v & 32'h1, 32'h0);

        // R9: capture edges on frozen counter
        wr(8'h38, 32'h0); wr(8'h28, 32'h7);
        wr(8'h3C, 32'h777); wr(8'h38, 32'h100); pin(1'b1);
        rd(8'h50, v); chk("R9 rising cap", v, 32'h777);
        rd(8'h24, v); chk("R9 cap status", v & 32'h4, 32'h4);
        wr(8'h28, 32'h4); wr(8'h3C, 32'h888); pin(1'b0);
        rd(8'h50, v); chk("R9 falling ignored", v, 32'h777);
        rd(8'h24, v); chk("R9 no status", v & 32'h4, 32'h0);
        wr(8'h38, 32'h200); pin(1'b1); wr(8'h3C, 32'h999); pin(1'b0);
        rd(8'h50, v); chk("R9 falling cap", v, 32'h999);
        wr(8'h38, 32'h0); wr(8'h3C, 32'h555); pin(1'b1);
        rd(8'h50, v); chk("R9 none", v, 32'h999);
        wr(8'h38, 32'h300); wr(8'h3C, 32'h666); pin(1'b0);
        rd(8'h50, v); chk("R9 both", v, 32'h666);

        // R10: second-event mode
        wr(8'h28, 32'h7); wr(8'h38, 32'h2100); wr(8'h3C, 32'hAAA); pin(1'b1);
        rd(8'h50, v); chk("R10 first skipped", v, 32'h666);
        pin(1'b0); wr(8'h3C, 32'hBBB); pin(1'b1);
        rd(8'h50, v); chk("R10 second taken", v, 32'hBBB);

        // R11/R12: raw vs masked, irq
        wr(8'h38, 32'h0); wr(8'h28, 32'h7); wr(8'h30, 32'h7);
        wr(8'h4C, 32'h5); wr(8'h38, 32'h40); wr(8'h3C, 32'h5);
        rd(8'h24, v); chk("R11 raw visible", v, 32'h1);
        rd(8'h28, v); chk("R11 masked hidden", v, 32'h0);
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'h0);
        rd(8'h24, v); chk("R11 zero write", v, 32'h1);
        wr(8'h2C, 32'h1);
        rd(8'h28, v); chk("R11 masked view", v, 32'h1);
        chk("R12 irq high", {31'b0, irq}, 32'h1);
        wr(8'h28, 32'h1);
        rd(8'h24, v); chk("R11 cleared", v, 32'h0);
        chk("R12 irq low", {31'b0, irq}, 32'h0);

        // R13: soft reset
        wr(8'h3C, 32'h55); wr(8'h2C, 32'h7); wr(8'h40, 32'h9);
        wr(8'h54, 32'h2);
        rd(8'h10, v); chk("R13 busy", v, 32'h1);
        repeat (6) @(negedge clk);
        rd(8'h10, v); chk("R13 done", v, 32'h0);
        rd(8'h3C, v); chk("R13 counter", v, 32'h0);
        rd(8'h2C, v); chk("R13 enables", v, 32'h0);
        rd(8'h40, v); chk("R13 load", v, 32'h0);
        rd(8'h38, v); chk("R13 control", v, 32'h0);

        finish_run();
    end
endmodule